// File: doc/BRIEF.md
# Shared-Pin Compare Waveform Combiner

This block merges two timer compare waveforms onto one output pin. One waveform comes from a channel of a wide timer, the other from a channel of a narrow timer. Each channel has a 2-bit output mode field. A channel takes the pin over from the ordinary port data bit when its mode field is nonzero.

When both channels claim the pin at once, carrier modulation turns on by itself. In that case the port data bit no longer drives the pin. It picks how the two waveforms merge: 0 gives their AND and 1 gives their OR. The pin value passes through one flop on the system clock, so switching between sources cannot glitch the pad. The pad is driven only while the direction bit is 1.

Top module: `cmp_pin_mux`

## Requirements
- R1: While reset is asserted, the registered pin value is 0. Output enable follows the direction input without delay at all times.
- R2: When both mode fields are zero, the pin value one clock later equals the port data bit.
- R3: When only the wide-timer mode field is nonzero, the pin value one clock later equals the wide-timer compare bit, whatever the port data bit is.
- R4: When only the narrow-timer mode field is nonzero, the pin value one clock later equals the narrow-timer compare bit, whatever the port data bit is.
- R5: When both mode fields are nonzero and the port data bit is 0, the pin value one clock later is the AND of the two compare bits.
- R6: When both mode fields are nonzero and the port data bit is 1, the pin value one clock later is the OR of the two compare bits.
- R7: The modulation flag is 1 exactly when both mode fields are nonzero. There is no other enable.
- R8: The pad output equals the registered pin value when the direction bit is 1, and is high impedance (z) when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_cmp | input | 1 | Compare output of the wide-timer channel |
| narrow_cmp | input | 1 | Compare output of the narrow-timer channel |
| wide_mode | input | 2 | Compare output mode field of the wide-timer channel |
| narrow_mode | input | 2 | Compare output mode field of the narrow-timer channel |
| port_data | input | 1 | Port data bit; also selects AND (0) or OR (1) while modulating |
| port_dir | input | 1 | Data direction bit; 1 drives the pin |
| mod_on | output | 1 | Modulation active (combinational) |
| pin_val | output | 1 | Registered pin value |
| pin_oe | output | 1 | Pad output enable |
| pin_pad | inout | 1 | Pad, high impedance when not enabled |

## Verification
The hardest case to reach is the change from one-channel ownership into modulation. The port data bit steers the merge function in that same cycle, and one flop sits between the mux and the pad. The stimulus walks every combination of the two mode fields (all four encodings each) together with the data and compare bits. It then toggles the compare bits at random while the ownership changes. A model in the bench predicts every edge and compares the result one clock later.

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wide_cmp,
  input  logic       narrow_cmp,
  input  logic [1:0] wide_mode,
  input  logic [1:0] narrow_mode,
  input  logic       port_data,
  input  logic       port_dir,
  output logic       mod_on,
  output logic       pin_val,
  output logic       pin_oe,
  inout  wire        pin_pad
);
  logic wide_own, narrow_own, next_val;

  assign wide_own   = |wide_mode;
  assign narrow_own = |narrow_mode;
  assign mod_on     = wide_own & narrow_own;

  always_comb begin
    unique case ({wide_own, narrow_own})
      2'b11:   next_val = port_data ? (wide_cmp | narrow_cmp) : (wide_cmp & narrow_cmp);
      2'b10:   next_val = wide_cmp;
      2'b01:   next_val = narrow_cmp;
      default: next_val = port_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_val <= 1'b0;
    else        pin_val <= next_val;

  assign pin_oe  = port_dir;
  assign pin_pad = pin_oe ? pin_val : 1'bz;
endmodule

module cmp_pin_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wide_cmp,
  input logic       narrow_cmp,
  input logic [1:0] wide_mode,
  input logic [1:0] narrow_mode,
  input logic       port_data,
  input logic       port_dir,
  input logic       mod_on,
  input logic       pin_val,
  input logic       pin_oe
);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode == 2'b00 && narrow_mode == 2'b00) |=> pin_val == $past(port_data));
  p_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode != 2'b00 && narrow_mode == 2'b00) |=> pin_val == $past(wide_cmp));
  p_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode == 2'b00 && narrow_mode != 2'b00) |=> pin_val == $past(narrow_cmp));
  p_and_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_on && !port_data) |=> pin_val == ($past(wide_cmp) && $past(narrow_cmp)));
  p_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_on && port_data) |=> pin_val == ($past(wide_cmp) || $past(narrow_cmp)));
  p_auto_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mod_on == (wide_mode != 2'b00 && narrow_mode != 2'b00));
  p_oe_r8: assert property (@(posedge clk) disable iff (!rst_n) pin_oe == port_dir);
endmodule

bind cmp_pin_mux cmp_pin_mux_chk u_chk (.*);

// File: tb/cmp_pin_mux_bench.sv
module cmp_pin_mux_bench;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic wide_cmp = 0, narrow_cmp = 0, port_data = 0, port_dir = 0;
  logic [1:0] wide_mode = 0, narrow_mode = 0;
  logic mod_on, pin_val, pin_oe;
  wire  pin_pad;
  int tests = 0, fails = 0;
  bit expv;
  bit done = 0;

  cmp_pin_mux u_cmp_pin_mux (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit model(bit w, bit n, int wm, int nm, bit d);
    if (wm != 0 && nm != 0) return d ? (w | n) : (w & n);
    if (wm != 0) return w;
    if (nm != 0) return n;
    return d;
  endfunction

  task automatic chk(string req, logic act, logic exp_v);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp_v);
    end
  endtask

  task automatic step(bit w, bit n, int wm, int nm, bit d, bit dir, string req);
    wide_cmp = w; narrow_cmp = n; wide_mode = 2'(wm); narrow_mode = 2'(nm);
    port_data = d; port_dir = dir;
    #1;
    chk("R7", mod_on, (wm != 0 && nm != 0));
    expv = model(w, n, wm, nm, d);
    @(posedge clk); #2;
    chk(req, pin_val, expv);
    chk("R8", pin_pad, dir ? expv : 1'bz);
    chk("R8", pin_oe, dir);
  endtask

  function automatic string req_of(int wm, int nm, bit d);
    if (wm != 0 && nm != 0) return d ? "R6" : "R5";
    if (wm != 0) return "R3";
    if (nm != 0) return "R4";
    return "R2";
  endfunction

  initial begin
    #(CLK_PERIOD*100000);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    port_data = 1; port_dir = 1;
    repeat (2) @(posedge clk);
    #2;
    chk("R1", pin_val, 1'b0);
    chk("R1", pin_oe, 1'b1);
    rst_n = 1;
    @(negedge clk);
    for (int wm = 0; wm < 4; wm++)
      for (int nm = 0; nm < 4; nm++)
        for (int v = 0; v < 8; v++)
          step(v[0], v[1], wm, nm, v[2], 1'b1, req_of(wm, nm, v[2]));
    step(1, 1, 0, 0, 1, 1'b0, "R8");
    step(1, 0, 1, 0, 0, 1'b0, "R8");
    for (int i = 0; i < 400; i++) begin
      int wm = $urandom_range(0, 3);
      int nm = $urandom_range(0, 3);
      bit d = 1'($urandom);
      step(1'($urandom), 1'($urandom), wm, nm, d, 1'($urandom), req_of(wm, nm, d));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule